// File: doc/BRIEF.md
# Open-Row DRAM Bank Sequencer

This block drives the command interface of a single DRAM bank from a plain read/write request port. It remembers which row currently sits in the bank's row buffer and chooses the shortest legal command sequence for each access. A request to the open row needs only a column command. A request to another row first closes the open row, then opens the new one, then issues the column command. When no row is open, the close step is skipped. Every command strobe is held apart from the next by parameterised delays, counted in clock cycles.

A built-in refresh scheduler spreads row refreshes evenly across the retention window. Its tick spacing is the window length in clock cycles divided by the row count. Refresh rows are visited in cyclic order. A refresh that falls due waits for the access in flight to finish. It then takes priority over new requests: the open row is closed and the refresh command is issued, and the bank stays unavailable until the refresh delay has passed. Each bank instance keeps its own open-row state.

Top module: `bank_seq`

## Requirements
- R1: After reset no command strobe is active, `req_ready` is 1, `busy` is 0 and the first refresh targets row 0.
- R2: An accepted request whose row equals the open row issues only one column command, one cycle after acceptance. It is a read (`cmd` bit 2) when `req_write` is 0 and a write (`cmd` bit 3) when it is 1, with `cmd_col` equal to the request column.
- R3: An accepted request to a different row while a row is open issues precharge (`cmd` bit 1, `cmd_row` = old row) one cycle after acceptance. Activate (`cmd` bit 0, `cmd_row` = new row) follows T_RP cycles later, and the column command follows T_RCD cycles after that.
- R4: An accepted request while no row is open issues activate one cycle after acceptance, then the column command T_RCD cycles later, with no precharge.
- R5: After an activate the row stays open, so a following request to that row is served as in R2.
- R6: Refresh commands are spaced by RETENTION_US*CLK_MHZ/ROWS cycles, give or take the longest access and precharge delay.
- R7: Refresh commands (`cmd` bit 4) carry rows 0,1,2,... in order on `cmd_row` and wrap from ROWS-1 back to 0.
- R8: Before a refresh, any open row is precharged exactly T_RP cycles before the refresh command. The first access after a refresh is served as in R4.
- R9: From the refresh command through the following T_RFC-1 cycles, `req_ready` is 0 and `busy` is 1, so a waiting request is not granted.
- R10: A refresh that falls due never places a command between an accepted request's acceptance and its column command.
- R11: `cmd` is one-hot or zero in every cycle, and `busy` is always the inverse of `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Request row address |
| req_col | input | COL_W | Request column address |
| req_ready | output | 1 | Grant: request accepted on this edge when req_valid is 1 |
| busy | output | 1 | High whenever a request cannot be accepted |
| cmd | output | 5 | One-hot command strobe: bit0 activate, bit1 precharge, bit2 read, bit3 write, bit4 refresh |
| cmd_row | output | ROW_W | Row for activate, precharge and refresh |
| cmd_col | output | COL_W | Column for read and write |

## Verification
Directed requests cover three cases: the first access to a closed bank, repeated reads and writes to the same row, and a jump to another row. These separate the three sequence shapes and check their exact spacing. Random traffic drawn mostly from four rows mixes hits and misses with refreshes that arrive mid-access. This shows whether a due refresh waits for the column command and whether the open-row state is dropped afterwards. Random traffic across all rows, run long enough for many refreshes, checks the cyclic row order, the wrap to row 0 and the bounds on refresh spacing.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  localparam int CMD_W   = 5;
  localparam int CMD_ACT = 0;
  localparam int CMD_PRE = 1;
  localparam int CMD_RD  = 2;
  localparam int CMD_WR  = 3;
  localparam int CMD_REF = 4;
  localparam int DLY_W   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_RPRE,
    ST_RFC
  } seq_state_t;
endpackage

// File: rtl/bank_delay_ctr.sv
module bank_delay_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (open_set) begin
      open_vld <= 1'b1;
      open_row <= set_row;
    end else if (open_clr) begin
      open_vld <= 1'b0;
    end
  end

  assign hit = open_vld && (open_row == probe_row);
endmodule

// File: rtl/bank_refresh_sched.sv
module bank_refresh_sched #(
  parameter int ROWS     = 65536,
  parameter int INTERVAL = 48,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int TICK_W  = $clog2(INTERVAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pending,
  output logic [ROW_W-1:0] ptr
);
  logic [TICK_W-1:0] tick_q;
  logic              tick;

  assign tick = (tick_q == TICK_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      pending <= 1'b0;
      ptr     <= '0;
    end else begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (ack) ptr <= (ptr == ROW_W'(ROWS - 1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/bank_seq.sv
module bank_seq
  import bank_seq_pkg::*;
#(
  parameter int ROWS         = 65536,
  parameter int COL_W        = 10,
  parameter int CLK_MHZ      = 50,
  parameter int RETENTION_US = 64000,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 3,
  parameter int T_CL         = 2,
  parameter int T_RFC        = 8,
  localparam int ROW_W       = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             req_ready,
  output logic             busy,
  output logic [CMD_W-1:0] cmd,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col
);
  localparam int REF_INTERVAL = (RETENTION_US * CLK_MHZ) / ROWS;

  seq_state_t       state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [CMD_W-1:0] cmd_d;
  logic [ROW_W-1:0] cmd_row_d;
  logic [COL_W-1:0] cmd_col_d;
  logic             ld;
  logic [DLY_W-1:0] ld_val;
  logic             dly_zero;
  logic             ref_ack, ref_pending;
  logic [ROW_W-1:0] ref_ptr;
  logic             open_vld, hit;
  logic [ROW_W-1:0] open_row;
  logic             take;

  bank_delay_ctr #(.W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(dly_zero)
  );

  bank_refresh_sched #(.ROWS(ROWS), .INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending), .ptr(ref_ptr)
  );

  bank_row_tracker #(.ROW_W(ROW_W)) u_trk (
    .clk(clk), .rst(rst),
    .open_set(cmd_d[CMD_ACT]), .open_clr(cmd_d[CMD_PRE]),
    .set_row(cmd_row_d), .probe_row(req_row),
    .open_vld(open_vld), .open_row(open_row), .hit(hit)
  );

  assign req_ready = (state_q == ST_IDLE) && !ref_pending;
  assign busy      = !req_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    state_d   = state_q;
    cmd_d     = '0;
    cmd_row_d = cmd_row;
    cmd_col_d = cmd_col;
    ld        = 1'b0;
    ld_val    = '0;
    ref_ack   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pending) begin
          if (open_vld) begin
            cmd_d[CMD_PRE] = 1'b1;
            cmd_row_d      = open_row;
            ld             = 1'b1;
            ld_val         = DLY_W'(T_RP - 1);
            state_d        = ST_RPRE;
          end else begin
            cmd_d[CMD_REF] = 1'b1;
            cmd_row_d      = ref_ptr;
            ref_ack        = 1'b1;
            ld             = 1'b1;
            ld_val         = DLY_W'(T_RFC - 1);
            state_d        = ST_RFC;
          end
        end else if (take) begin
          ld = 1'b1;
          if (hit) begin
            cmd_d[req_write ? CMD_WR : CMD_RD] = 1'b1;
            cmd_col_d = req_col;
            ld_val    = DLY_W'(T_CL - 1);
            state_d   = ST_COL;
          end else if (open_vld) begin
            cmd_d[CMD_PRE] = 1'b1;
            cmd_row_d      = open_row;
            ld_val         = DLY_W'(T_RP - 1);
            state_d        = ST_PRE;
          end else begin
            cmd_d[CMD_ACT] = 1'b1;
            cmd_row_d      = req_row;
            ld_val         = DLY_W'(T_RCD - 1);
            state_d        = ST_ACT;
          end
        end
      end
      ST_PRE: if (dly_zero) begin
        cmd_d[CMD_ACT] = 1'b1;
        cmd_row_d      = row_q;
        ld             = 1'b1;
        ld_val         = DLY_W'(T_RCD - 1);
        state_d        = ST_ACT;
      end
      ST_ACT: if (dly_zero) begin
        cmd_d[wr_q ? CMD_WR : CMD_RD] = 1'b1;
        cmd_col_d = col_q;
        ld        = 1'b1;
        ld_val    = DLY_W'(T_CL - 1);
        state_d   = ST_COL;
      end
      ST_RPRE: if (dly_zero) begin
        cmd_d[CMD_REF] = 1'b1;
        cmd_row_d      = ref_ptr;
        ref_ack        = 1'b1;
        ld             = 1'b1;
        ld_val         = DLY_W'(T_RFC - 1);
        state_d        = ST_RFC;
      end
      ST_COL, ST_RFC: if (dly_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd     <= '0;
      cmd_row <= '0;
      cmd_col <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd     <= cmd_d;
      cmd_row <= cmd_row_d;
      cmd_col <= cmd_col_d;
      if (take) begin
        row_q <= req_row;
        col_q <= req_col;
        wr_q  <= req_write;
      end
    end
  end
endmodule

// File: rtl/bank_seq_chk.sv
module bank_seq_chk
  import bank_seq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic [CMD_W-1:0] cmd
);
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd)); // R11

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd == '0)); // R1

  AST_GRANT_YIELDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd != '0)); // R2

  AST_PRE_NOT_COL: assert property (@(posedge clk) disable iff (rst)
    cmd[CMD_PRE] |=> !(cmd[CMD_RD] || cmd[CMD_WR])); // R3

  AST_REF_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    cmd[CMD_REF] |-> (busy && !req_ready)); // R9

  AST_NO_REF_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !cmd[CMD_REF]); // R10
endmodule

bind bank_seq bank_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .cmd(cmd)
);

// File: tb/bank_seq_tb_top.sv
module bank_seq_tb_top;
  localparam int ROWS = 32, COL_W = 6, CLK_MHZ = 50, RET_US = 32;
  localparam int T_RP = 3, T_RCD = 4, T_CL = 2, T_RFC = 6;
  localparam int ROW_W = $clog2(ROWS);
  localparam int INTERVAL = (RET_US * CLK_MHZ) / ROWS;
  localparam int SLACK = T_RP + T_RCD + T_CL + T_RP + 4;
  localparam int MAX_CYC = 150000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, busy;
  logic [4:0] cmd;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bank_seq #(.ROWS(ROWS), .COL_W(COL_W), .CLK_MHZ(CLK_MHZ), .RETENTION_US(RET_US),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL), .T_RFC(T_RFC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_ready(req_ready), .busy(busy),
    .cmd(cmd), .cmd_row(cmd_row), .cmd_col(cmd_col));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int col_code(input bit wr);
    return wr ? 8 : 4;
  endfunction

  // expected command queues built by the reference model
  int    q_cmd[$];
  int    q_addr[$];
  int    q_gap[$];
  string q_tag[$];

  bit exp_open = 0;
  int exp_row = 0;
  int exp_ptr = 0;
  bit after_ref = 0;
  bit ref_pre_seen = 0;
  bit any_ref = 0;
  bit wrap_seen = 0;
  int ref_count = 0;
  int cyc = 0, last_stamp = 0, pre_stamp = 0, ref_stamp = 0, last_ref_row = -1;

  always @(negedge clk) begin
    #2;
    if (!rst && !done) begin
      cyc++;
      check(busy == !req_ready, "R11 busy vs ready", busy, !req_ready);
      check($countones(cmd) <= 1, "R11 onehot", cmd, 0);
      if (any_ref && (cyc - ref_stamp) < T_RFC)
        check(!req_ready && busy, "R9 blocked during refresh", req_ready, 0);
      if (cmd != 0) begin
        if (q_cmd.size() != 0) begin
          check(int'(cmd) == q_cmd[0], {q_tag[0], " cmd"}, cmd, q_cmd[0]);
          if (cmd[2] || cmd[3])
            check(int'(cmd_col) == q_addr[0], {q_tag[0], " col"}, cmd_col, q_addr[0]);
          else
            check(int'(cmd_row) == q_addr[0], {q_tag[0], " row"}, cmd_row, q_addr[0]);
          check(cyc - last_stamp == q_gap[0], {q_tag[0], " spacing"}, cyc - last_stamp, q_gap[0]);
          last_stamp = cyc;
          void'(q_cmd.pop_front()); void'(q_addr.pop_front());
          void'(q_gap.pop_front()); void'(q_tag.pop_front());
        end else if (cmd[1]) begin
          check(exp_open && !ref_pre_seen, "R8 refresh precharge expected", exp_open, 1);
          check(int'(cmd_row) == exp_row, "R8 refresh precharge row", cmd_row, exp_row);
          exp_open = 0; ref_pre_seen = 1; pre_stamp = cyc;
        end else if (cmd[4]) begin
          check(!exp_open, "R8 row closed before refresh", exp_open, 0);
          if (ref_pre_seen) check(cyc - pre_stamp == T_RP, "R8 pre to ref", cyc - pre_stamp, T_RP);
          check(int'(cmd_row) == exp_ptr, "R7 refresh row", cmd_row, exp_ptr);
          if (!any_ref) check(cmd_row == 0, "R1 first refresh row", cmd_row, 0);
          if (any_ref) begin
            check(cyc - ref_stamp <= INTERVAL + SLACK, "R6 refresh gap max", cyc - ref_stamp, INTERVAL + SLACK);
            check(cyc - ref_stamp >= INTERVAL - SLACK, "R6 refresh gap min", cyc - ref_stamp, INTERVAL - SLACK);
          end else
            check(cyc <= INTERVAL + SLACK, "R6 first refresh", cyc, INTERVAL + SLACK);
          if (last_ref_row == ROWS - 1 && cmd_row == 0) wrap_seen = 1;
          last_ref_row = int'(cmd_row);
          exp_ptr = (exp_ptr + 1) % ROWS;
          ref_pre_seen = 0; any_ref = 1; ref_stamp = cyc; after_ref = 1; ref_count++;
        end else
          check(0, "R10 unexpected command", cmd, 0);
      end
      if (req_valid && req_ready) begin
        check(q_cmd.size() == 0, "R10 accept while busy", q_cmd.size(), 0);
        last_stamp = cyc;
        if (exp_open && exp_row == int'(req_row)) begin
          q_cmd.push_back(col_code(req_write)); q_addr.push_back(int'(req_col));
          q_gap.push_back(1); q_tag.push_back("R2/R5 hit");
        end else begin
          if (exp_open) begin
            q_cmd.push_back(2); q_addr.push_back(exp_row); q_gap.push_back(1); q_tag.push_back("R3 miss pre");
            q_cmd.push_back(1); q_addr.push_back(int'(req_row)); q_gap.push_back(T_RP); q_tag.push_back("R3 miss act");
            q_cmd.push_back(col_code(req_write)); q_addr.push_back(int'(req_col));
            q_gap.push_back(T_RCD); q_tag.push_back("R3 miss col");
          end else begin
            q_cmd.push_back(1); q_addr.push_back(int'(req_row)); q_gap.push_back(1);
            q_tag.push_back(after_ref ? "R8 act after refresh" : "R4 closed act");
            q_cmd.push_back(col_code(req_write)); q_addr.push_back(int'(req_col));
            q_gap.push_back(T_RCD); q_tag.push_back("R4 closed col");
          end
          exp_open = 1; exp_row = int'(req_row);
        end
        after_ref = 0;
      end
    end
  end

  task automatic do_req(input int row, input int col, input bit wr);
    @(negedge clk);
    req_valid = 1; req_row = ROW_W'(row); req_col = COL_W'(col); req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(MAX_CYC * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAX_CYC);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #3;
    check(cmd == 0, "R1 reset cmd", cmd, 0);
    check(req_ready == 1, "R1 reset ready", req_ready, 1);
    check(busy == 0, "R1 reset busy", busy, 0);
    // directed: closed miss, hits, row change
    do_req(5, 3, 0);
    idle(8);
    do_req(5, 7, 0);
    idle(4);
    do_req(5, 9, 1);
    idle(4);
    do_req(9, 1, 0);
    idle(8);
    // random, few rows for frequent hits
    for (int i = 0; i < 300; i++) begin
      do_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
      idle(int'($urandom_range(0, 6)));
    end
    // random, any row
    for (int i = 0; i < 300; i++) begin
      do_req(int'($urandom_range(0, ROWS - 1)), int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
      idle(int'($urandom_range(0, 10)));
    end
    idle(2 * INTERVAL);
    check(q_cmd.size() == 0, "R10 all requests served", q_cmd.size(), 0);
    check(ref_count > ROWS, "R7 refresh count", ref_count, ROWS + 1);
    check(wrap_seen, "R7 wrap to row 0", wrap_seen, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule